// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the fifteen general registers that software addresses as numbers 0 to 14. Several exception modes keep their own copies of some of these registers, so the same register number can name different storage depending on the mode. A 5-bit mode input chooses the view. In the fast-interrupt mode, registers 8 to 14 are private copies and registers 0 to 7 are shared. In the four other exception modes, only registers 13 and 14 are private. The normal (user) view uses the base storage for all fifteen numbers. Register number 15 is the program counter, which is shared by every mode and kept outside this block.

There are two combinational read ports and one write port. All three are addressed by a 4-bit register number and all three use the mode present in the same cycle. A write takes effect at the rising clock edge. A read returns what the storage holds before that edge, so a read of a register that is being written in the same cycle returns the old contents. The storage has 30 physical entries: 15 base entries, 7 for the fast-interrupt bank, and 2 for each of the four other exception modes. A mode code that is not defined falls back to the user view.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-low reset clears every physical entry, so that afterwards every register reads 0 in every mode.
- R2: User mode (mode code 5'b10000) maps register numbers 0 to 14 onto the 15 base entries.
- R3: Fast-interrupt mode (5'b10001) has private entries for registers 8 to 14 and shares registers 0 to 7 with user mode.
- R4: Modes 5'b10010, 5'b10011, 5'b10111 and 5'b11011 each have private registers 13 and 14, one pair per mode, and share registers 0 to 12 with user mode.
- R5: Any other mode code reads and writes the user-mode view.
- R6: Register number 15 always reads as 0, and a write to number 15 changes no register.
- R7: A read of the register being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R8: Reads and writes use the bank selected by the mode input in that same cycle.
- R9: While the write enable is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Register number to write |
| wr_data_i | input | 32 | Write data |
| rd_addr_a_i | input | 4 | Register number for read port A |
| rd_data_a_o | output | 32 | Read port A data (combinational) |
| rd_addr_b_i | input | 4 | Register number for read port B |
| rd_data_b_o | output | 32 | Read port B data (combinational) |

## Verification
The bench first writes every register number once in each of ten mode codes: the six defined codes and four undefined ones. Each write carries a value that encodes its mode, its register number and its order in the sequence. After every write it reads all sixteen numbers through both ports in all ten modes and compares them against a bench model of the banking. This tells a wrongly shared or wrongly private entry apart from a correct one, because a later write that wrongly overwrites an entry leaves a value that does not match. Separate patterns cover the following cases:
- a write with the same-cycle read of the same register, which separates the old value from the new one;
- a cycle with the write enable held low, which shows that nothing changes;
- writes to number 15;
- a final reset, after which every register must read zero.

// File: rtl/bankrf_pkg.sv
// Package: shared constants and mode codes for the banked register file.
// Assumes the register number is 4 bits wide and that number 15 lives outside the file.
package bankrf_pkg;
    localparam int NUM_LOGICAL = 16;
    localparam int ADDR_W      = $clog2(NUM_LOGICAL);
    localparam int BASE_REGS   = NUM_LOGICAL - 1;      // numbers 0..14
    localparam int FIQ_FIRST   = 8;                    // first privately banked number in FIQ
    localparam int FIQ_REGS    = BASE_REGS - FIQ_FIRST;
    localparam int PAIR_FIRST  = 13;                   // first banked number in the other modes
    localparam int PAIR_REGS   = BASE_REGS - PAIR_FIRST;
    localparam int NUM_PAIRS   = 4;
    localparam int FIQ_BASE    = BASE_REGS;
    localparam int IRQ_BASE    = FIQ_BASE + FIQ_REGS;
    localparam int SVC_BASE    = IRQ_BASE + PAIR_REGS;
    localparam int ABT_BASE    = SVC_BASE + PAIR_REGS;
    localparam int UND_BASE    = ABT_BASE + PAIR_REGS;
    localparam int NUM_PHYS    = BASE_REGS + FIQ_REGS + NUM_PAIRS * PAIR_REGS;
    localparam int PHYS_W      = $clog2(NUM_PHYS);

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011
    } mode_e;
endpackage

// File: rtl/bankrf_map.sv
// Module: translates a register number plus a mode code into a physical entry index.
// Assumes undefined mode codes select the user view, and that number 15 is flagged
// invalid (index forced to 0) so that the caller can gate it.
module bankrf_map
    import bankrf_pkg::*;
(
    input  logic [4:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              valid_o
);
    localparam int FIQ_OFS  = FIQ_BASE - FIQ_FIRST;
    localparam int IRQ_OFS  = IRQ_BASE - PAIR_FIRST;
    localparam int SVC_OFS  = SVC_BASE - PAIR_FIRST;
    localparam int ABT_OFS  = ABT_BASE - PAIR_FIRST;
    localparam int UND_OFS  = UND_BASE - PAIR_FIRST;

    logic in_fiq_range;
    logic in_pair_range;

    // Classify the register number against the two banking ranges.
    always_comb begin
        valid_o       = (int'(addr_i) < BASE_REGS);
        in_fiq_range  = valid_o && (int'(addr_i) >= FIQ_FIRST);
        in_pair_range = valid_o && (int'(addr_i) >= PAIR_FIRST);
    end

    // Select the physical index from the mode and the range.
    always_comb begin
        phys_o = PHYS_W'(addr_i);
        case (mode_i)
            MODE_FIQ: if (in_fiq_range)  phys_o = PHYS_W'(int'(addr_i) + FIQ_OFS);
            MODE_IRQ: if (in_pair_range) phys_o = PHYS_W'(int'(addr_i) + IRQ_OFS);
            MODE_SVC: if (in_pair_range) phys_o = PHYS_W'(int'(addr_i) + SVC_OFS);
            MODE_ABT: if (in_pair_range) phys_o = PHYS_W'(int'(addr_i) + ABT_OFS);
            MODE_UND: if (in_pair_range) phys_o = PHYS_W'(int'(addr_i) + UND_OFS);
            default:  phys_o = PHYS_W'(addr_i);
        endcase
        if (!valid_o) phys_o = '0;
    end
endmodule

// File: rtl/bankrf_array.sv
// Module: flat storage of physical entries with several combinational read ports
// and one write port that writes on the clock edge. Assumes the indices are already
// mapped; an index at or beyond DEPTH reads 0 and is never written.
module bankrf_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 30,
    parameter int NUM_RD = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     ridx_i  [NUM_RD],
    output logic [DATA_W-1:0] rdata_o [NUM_RD]
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Clear all entries on reset; otherwise update the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i && (int'(widx_i) < DEPTH)) begin
            mem_q[widx_i] <= wdata_i;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        // Combinational read of the stored (pre-edge) contents.
        always_comb begin
            rdata_o[p] = '0;
            if (int'(ridx_i[p]) < DEPTH) rdata_o[p] = mem_q[ridx_i[p]];
        end
    end
endmodule

// File: rtl/banked_regfile.sv
// Module: top of the mode-banked register file. It has two read ports and one write
// port, and all of them are translated by the mode in the same cycle. Assumes number 15
// (the program counter) is held elsewhere: it reads 0 here and writes to it are dropped.
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [3:0]        rd_addr_a_i,
    output logic [DATA_W-1:0] rd_data_a_o,
    input  logic [3:0]        rd_addr_b_i,
    output logic [DATA_W-1:0] rd_data_b_o
);
    localparam int NUM_RD = 2;

    logic [ADDR_W-1:0] rd_addr  [NUM_RD];
    logic [PHYS_W-1:0] rd_phys  [NUM_RD];
    logic              rd_valid [NUM_RD];
    logic [DATA_W-1:0] rd_raw   [NUM_RD];
    logic [DATA_W-1:0] rd_data  [NUM_RD];
    logic [PHYS_W-1:0] wr_phys;
    logic              wr_valid;
    logic [PHYS_W-1:0] phys_a;
    logic [PHYS_W-1:0] phys_b;

    // Gather the read addresses into an indexed form.
    always_comb begin
        rd_addr[0] = rd_addr_a_i;
        rd_addr[1] = rd_addr_b_i;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rmap
        bankrf_map u_map (
            .mode_i  (mode_i),
            .addr_i  (rd_addr[p]),
            .phys_o  (rd_phys[p]),
            .valid_o (rd_valid[p])
        );
        // Number 15 is not stored here and reads as zero.
        always_comb rd_data[p] = rd_valid[p] ? rd_raw[p] : '0;
    end

    bankrf_map u_wmap (
        .mode_i  (mode_i),
        .addr_i  (wr_addr_i),
        .phys_o  (wr_phys),
        .valid_o (wr_valid)
    );

    bankrf_array #(
        .DATA_W (DATA_W),
        .DEPTH  (NUM_PHYS),
        .NUM_RD (NUM_RD)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i && wr_valid),
        .widx_i  (wr_phys),
        .wdata_i (wr_data_i),
        .ridx_i  (rd_phys),
        .rdata_o (rd_raw)
    );

    // Drive the ports and expose the mapped indices for checking.
    always_comb begin
        rd_data_a_o = rd_data[0];
        rd_data_b_o = rd_data[1];
        phys_a      = rd_phys[0];
        phys_b      = rd_phys[1];
    end
endmodule

// File: rtl/bankrf_chk.sv
// Module: property checker for banked_regfile, attached with bind.
// Assumes the bench holds reset low at time zero.
module bankrf_chk
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic              wr_en_i,
    input logic [3:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [3:0]        rd_addr_a_i,
    input logic [DATA_W-1:0] rd_data_a_o,
    input logic [3:0]        rd_addr_b_i,
    input logic [DATA_W-1:0] rd_data_b_o,
    input logic [PHYS_W-1:0] phys_a,
    input logic [PHYS_W-1:0] phys_b
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rd_data_a_o == '0 && rd_data_b_o == '0)); // R1
    AST_USER_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_USR && rd_addr_a_i != 4'hF) |-> (phys_a == PHYS_W'(rd_addr_a_i))); // R2
    AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b_i < 4'd8) |-> (phys_b == PHYS_W'(rd_addr_b_i))); // R3
    AST_FIQ_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FIQ && rd_addr_a_i >= 4'd8 && rd_addr_a_i != 4'hF)
        |-> (int'(phys_a) >= FIQ_BASE && int'(phys_a) < IRQ_BASE)); // R3
    AST_PAIR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_FIQ && rd_addr_a_i < 4'd13) |-> (phys_a == PHYS_W'(rd_addr_a_i))); // R4
    AST_PC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a_i == 4'hF) |-> (rd_data_a_o == '0)); // R6
    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != 4'hF)
        |=> (!(rd_addr_a_i == $past(wr_addr_i) && mode_i == $past(mode_i))
             || rd_data_a_o == $past(wr_data_i))); // R7
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i
        |=> (!(rd_addr_b_i == $past(rd_addr_b_i) && mode_i == $past(mode_i))
             || $stable(rd_data_b_o))); // R9
endmodule

bind banked_regfile bankrf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_a_i (rd_addr_a_i),
    .rd_data_a_o (rd_data_a_o),
    .rd_addr_b_i (rd_addr_b_i),
    .rd_data_b_o (rd_data_b_o),
    .phys_a      (phys_a),
    .phys_b      (phys_b)
);

// File: tb/banked_regfile_bench.sv
// Bench: near-exhaustive sweep of every register number in all defined and four
// undefined mode codes, compared against an arithmetic model of the banking.
module banked_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'b10000;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  rd_addr_a_i = '0;
    logic [31:0] rd_data_a_o;
    logic [3:0]  rd_addr_b_i = '0;
    logic [31:0] rd_data_b_o;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] model [30];
    logic [4:0]  modes [10] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111,
                                5'b11011, 5'b00000, 5'b10100, 5'b11111, 5'b01111};

    always #10 clk = ~clk;   // 50 MHz

    banked_regfile u_banked_regfile (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
        .rd_addr_b_i(rd_addr_b_i), .rd_data_b_o(rd_data_b_o)
    );

    // Model index: -1 for number 15; banked ranges per mode; undefined -> user.
    function automatic int phys(input logic [4:0] m, input int a);
        if (a == 15) return -1;
        case (m)
            5'b10001: return (a >= 8)  ? 15 + (a - 8)  : a;
            5'b10010: return (a >= 13) ? 22 + (a - 13) : a;
            5'b10011: return (a >= 13) ? 24 + (a - 13) : a;
            5'b10111: return (a >= 13) ? 26 + (a - 13) : a;
            5'b11011: return (a >= 13) ? 28 + (a - 13) : a;
            default:  return a;
        endcase
    endfunction

    function automatic string tag(input logic [4:0] m, input int a);
        if (a == 15) return "R6";
        case (m)
            5'b10000: return "R2";
            5'b10001: return "R3";
            5'b10010, 5'b10011, 5'b10111, 5'b11011: return "R4";
            default:  return "R5";
        endcase
    endfunction

    function automatic logic [31:0] expect_of(input logic [4:0] m, input int a);
        int p = phys(m, a);
        return (p < 0) ? 32'h0 : model[p];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %08h expected %08h (mode %05b)", req, act, exp, mode_i);
        end
    endtask

    // Read every number through both ports in every mode; write enable must be low.
    task automatic sweep_reads(input string override);
        for (int mi = 0; mi < 10; mi++) begin
            for (int a = 0; a < 16; a++) begin
                mode_i = modes[mi];
                rd_addr_a_i = 4'(a);
                rd_addr_b_i = 4'(15 - a);
                #1;
                check(override == "" ? tag(modes[mi], a) : override,
                      rd_data_a_o, expect_of(modes[mi], a));
                check(override == "" ? tag(modes[mi], 15 - a) : override,
                      rd_data_b_o, expect_of(modes[mi], 15 - a));
            end
        end
    endtask

    // One write in the given mode; the same-cycle read must see the old value.
    task automatic do_write(input logic [4:0] m, input int a, input logic [31:0] d);
        @(negedge clk);
        mode_i = m; wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = d;
        rd_addr_a_i = 4'(a);
        #2;
        check("R7 old", rd_data_a_o, expect_of(m, a));
        @(posedge clk);
        if (phys(m, a) >= 0) model[phys(m, a)] = d;
        #1;
        wr_en_i = 1'b0;
        check("R7 new R8", rd_data_a_o, expect_of(m, a));
    endtask

    initial begin
        int seq = 0;
        for (int i = 0; i < 30; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        sweep_reads("R1");
        for (int mi = 0; mi < 10; mi++) begin
            for (int a = 0; a < 16; a++) begin
                seq++;
                do_write(modes[mi], a, {3'b101, modes[mi], 4'(a), 4'h0, 16'(seq)});
                sweep_reads("");
            end
        end
        // R9: enable low with live address and data leaves everything unchanged.
        @(negedge clk);
        mode_i = 5'b10001; wr_addr_i = 4'd9; wr_data_i = 32'hDEAD_BEEF;
        repeat (2) @(posedge clk);
        #1;
        sweep_reads("R9");
        // R6: writing number 15 in several modes leaves every register unchanged.
        do_write(5'b10000, 15, 32'hFFFF_FFFF);
        do_write(5'b10001, 15, 32'h1234_5678);
        sweep_reads("R6");
        // R1: reset again clears every entry.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 30; i++) model[i] = '0;
        #1 rst_n = 1'b1;
        sweep_reads("R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20 * 200000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule